// File: doc/BRIEF.md
# Scaled-Index Address Generator

This block produces effective addresses for an integer pipeline. It takes a base operand and an index operand. It scales the index by 2, 4 or 8, or leaves it unscaled, and adds the scaled index to the base in one full-width adder. The index can be used at full width, or it can be reduced to its low 32 bits and zero-extended before scaling. The second choice lets a 64-bit datapath index arrays with unsigned 32-bit counters and needs no separate extension step. One further operation takes the zero-extended low word of the index and shifts it left by a 6-bit immediate without adding the base.

The datapath width is a parameter and may be 32 or 64. The word-reduced operations and the immediate shift exist only at width 64. At width 32 the block raises an unsupported flag for those operations and returns zero. The result and the flag are registered, so each appears one clock after its operands are sampled. Decoding, operand fetch and trap handling stay in the surrounding pipeline.

Top module: `agen_shadd`

## Requirements
- R1: For op_i 0, 1 and 2 the result is opb_i + (opa_i << k), with k = 1, 2 and 3 respectively, at both widths.
- R2: At width 64, for op_i 4, 5 and 6 the result is opb_i + (zero-extended opa_i[31:0] << k), with k = 1, 2 and 3 respectively.
- R3: At width 64, op_i 3 gives opb_i + zero-extended opa_i[31:0]. With opb_i equal to zero the result is the zero-extended low word.
- R4: At width 64, op_i 7 gives the zero-extended opa_i[31:0] shifted left by imm_i[5:0]. opb_i has no effect on this result.
- R5: All sums and shifts wrap modulo 2^XLEN. Carries and bits shifted out above bit XLEN-1 are dropped.
- R6: At width 32, op_i 3 to 7 set unsup_o to 1 and res_o to zero. In every other case unsup_o is 0.
- R7: res_o and unsup_o are registered. They change only at a rising clock edge and reflect the inputs sampled at that edge.
- R8: While rst is high at a rising edge, res_o becomes zero and unsup_o becomes 0.
- R9: For op_i 3 to 7 at width 64, opa_i[63:32] has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation select: 0/1/2 full-width scale-by-2/4/8 and add; 3 word add; 4/5/6 word scale-by-2/4/8 and add; 7 word immediate shift |
| opa_i | input | XLEN | Index operand |
| opb_i | input | XLEN | Base operand |
| imm_i | input | 6 | Shift amount for op_i 7 |
| res_o | output | XLEN | Registered result |
| unsup_o | output | 1 | Registered flag for an operation that this width does not support |

## Verification
The assertions check the following on every cycle:
- the reset value of both outputs;
- that a raised unsupported flag always comes with a zero result;
- the scale-by-2 full-width sum against the previous cycle's operands;
- that a word-reduced operation whose low index word is zero returns the base unchanged, whatever the upper bits hold.

The bench covers the rest. It sweeps every operation against a grid of corner operands, including all-ones, lone high bits and split-word patterns, and checks each result against a 128-bit sum truncated to the datapath width. It sweeps all 64 immediate shift amounts, adds random vectors, and shows that outputs hold between edges. A 32-bit instance is driven alongside to check the unsupported-operation behaviour.

// File: rtl/agen_pkg.sv
package agen_pkg;
  typedef enum logic [2:0] {
    OP_SC2   = 3'd0,
    OP_SC4   = 3'd1,
    OP_SC8   = 3'd2,
    OP_WADD  = 3'd3,
    OP_WSC2  = 3'd4,
    OP_WSC4  = 3'd5,
    OP_WSC8  = 3'd6,
    OP_WSHL  = 3'd7
  } agen_op_e;

  localparam int unsigned IMM_W = 6;

  // operations that take only the low 32 bits of the index
  function automatic logic is_word_op(input agen_op_e op);
    return (op >= OP_WADD);
  endfunction
endpackage

// File: rtl/agen_operand.sv
module agen_operand
  import agen_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  agen_op_e              op,
  input  logic [XLEN-1:0]       opa,
  input  logic [IMM_W-1:0]      imm,
  output logic [XLEN-1:0]       idx_scaled,
  output logic                  use_base
);
  logic [XLEN-1:0]  idx_src;
  logic [IMM_W-1:0] shamt;

  // zero-extension of the low word only exists when the datapath is wider
  generate
    if (XLEN > 32) begin : g_wide
      always_comb begin
        if (is_word_op(op)) idx_src = {{(XLEN-32){1'b0}}, opa[31:0]};
        else                idx_src = opa;
      end
    end else begin : g_narrow
      always_comb idx_src = opa;
    end
  endgenerate

  always_comb begin
    unique case (op)
      OP_SC2, OP_WSC2: shamt = IMM_W'(1);
      OP_SC4, OP_WSC4: shamt = IMM_W'(2);
      OP_SC8, OP_WSC8: shamt = IMM_W'(3);
      OP_WADD:         shamt = '0;
      default:         shamt = imm;
    endcase
  end

  assign idx_scaled = idx_src << shamt;
  assign use_base   = (op != OP_WSHL);
endmodule

// File: rtl/agen_sum.sv
module agen_sum #(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] base,
  input  logic [XLEN-1:0] idx,
  input  logic            use_base,
  output logic [XLEN-1:0] sum
);
  logic [XLEN-1:0] base_g;
  assign base_g = use_base ? base : '0;
  // wrap modulo 2^XLEN: the carry out is dropped
  assign sum = base_g + idx;
endmodule

// File: rtl/agen_legal.sv
module agen_legal
  import agen_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  agen_op_e op,
  output logic     unsup
);
  generate
    if (XLEN == 64) begin : g_all_ok
      assign unsup = 1'b0;
    end else begin : g_word_bad
      assign unsup = is_word_op(op);
    end
  endgenerate
endmodule

// File: rtl/agen_shadd.sv
module agen_shadd
  import agen_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2:0]          op_i,
  input  logic [XLEN-1:0]     opa_i,
  input  logic [XLEN-1:0]     opb_i,
  input  logic [IMM_W-1:0]    imm_i,
  output logic [XLEN-1:0]     res_o,
  output logic                unsup_o
);
  agen_op_e        op;
  logic [XLEN-1:0] idx_scaled;
  logic            use_base;
  logic [XLEN-1:0] sum;
  logic            unsup;

  assign op = agen_op_e'(op_i);

  agen_operand #(.XLEN(XLEN)) u_operand (
    .op         (op),
    .opa        (opa_i),
    .imm        (imm_i),
    .idx_scaled (idx_scaled),
    .use_base   (use_base)
  );

  agen_sum #(.XLEN(XLEN)) u_sum (
    .base     (opb_i),
    .idx      (idx_scaled),
    .use_base (use_base),
    .sum      (sum)
  );

  agen_legal #(.XLEN(XLEN)) u_legal (
    .op    (op),
    .unsup (unsup)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o   <= '0;
      unsup_o <= 1'b0;
    end else begin
      res_o   <= unsup ? '0 : sum;
      unsup_o <= unsup;
    end
  end
endmodule

// File: rtl/agen_shadd_chk.sv
module agen_shadd_chk #(
  parameter int unsigned XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic [2:0]      op_i,
  input logic [XLEN-1:0] opa_i,
  input logic [XLEN-1:0] opb_i,
  input logic [XLEN-1:0] res_o,
  input logic            unsup_o
);
  // R8
  a_r8_reset_clears: assert property (@(posedge clk)
    rst |=> (res_o == '0 && !unsup_o));

  // R6
  a_r6_unsup_zero: assert property (@(posedge clk) disable iff (rst)
    unsup_o |-> res_o == '0);

  // R1, R7
  a_r1_scale2_sum: assert property (@(posedge clk) disable iff (rst)
    (op_i == 3'd0) |=> res_o == $past(opb_i) + ($past(opa_i) << 1));

  // R9
  a_r9_upper_ignored: assert property (@(posedge clk) disable iff (rst)
    ((XLEN == 64) && op_i >= 3'd3 && op_i <= 3'd6 && opa_i[31:0] == 32'd0)
      |=> res_o == $past(opb_i));

  // R6
  a_r6_wide_never_unsup: assert property (@(posedge clk) disable iff (rst)
    (XLEN == 64) |=> !unsup_o);
endmodule

bind agen_shadd agen_shadd_chk #(.XLEN(XLEN)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .op_i    (op_i),
  .opa_i   (opa_i),
  .opb_i   (opb_i),
  .res_o   (res_o),
  .unsup_o (unsup_o)
);

// File: tb/agen_shadd_test.sv
`timescale 1ns/1ps
module agen_shadd_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  op_s = '0;
  logic [63:0] a_s = '0, b_s = '0;
  logic [5:0]  imm_s = '0;
  logic [63:0] res64;
  logic        uns64;
  logic [31:0] res32;
  logic        uns32;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;
  logic [63:0] prev64 = '0;
  logic [31:0] prev32 = '0;

  always #2 clk = ~clk;

  agen_shadd #(.XLEN(64)) uut (
    .clk(clk), .rst(rst), .op_i(op_s), .opa_i(a_s), .opb_i(b_s),
    .imm_i(imm_s), .res_o(res64), .unsup_o(uns64));

  agen_shadd #(.XLEN(32)) uut_w32 (
    .clk(clk), .rst(rst), .op_i(op_s), .opa_i(a_s[31:0]), .opb_i(b_s[31:0]),
    .imm_i(imm_s), .res_o(res32), .unsup_o(uns32));

  // expected value: 128-bit sum, then truncation (R5)
  function automatic logic [63:0] ref64(input logic [2:0] op, input logic [63:0] a,
                                        input logic [63:0] b, input logic [5:0] imm);
    logic [127:0] idx, base, s;
    int sh;
    idx  = (op < 3) ? {64'd0, a} : {96'd0, a[31:0]};
    if (op < 3)      sh = int'(op) + 1;
    else if (op < 7) sh = int'(op) - 3;
    else             sh = int'(imm);
    base = (op == 3'd7) ? 128'd0 : {64'd0, b};
    s = base + (idx << sh);
    return s[63:0];
  endfunction

  function automatic logic [63:0] ref32(input logic [2:0] op, input logic [63:0] a,
                                        input logic [63:0] b);
    logic [127:0] s;
    if (op >= 3) return 64'd0;
    s = {96'd0, b[31:0]} + ({96'd0, a[31:0]} << (int'(op) + 1));
    return {32'd0, s[31:0]};
  endfunction

  function automatic logic [63:0] corner(input int i);
    case (i)
      0: return 64'h0;
      1: return 64'h1;
      2: return 64'hFFFF_FFFF_FFFF_FFFF;
      3: return 64'h8000_0000_0000_0000;
      4: return 64'h0000_0000_8000_0000;
      5: return 64'hFFFF_FFFF_0000_0000;
      6: return 64'h0000_0000_FFFF_FFFF;
      default: return 64'h1234_5678_9ABC_DEF0;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] op);
    if (op < 3) return "R1";
    if (op == 3) return "R3";
    if (op < 7) return "R2";
    return "R4";
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic run(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b,
                     input logic [5:0] imm, input string tag);
    logic [63:0] e64, e32;
    @(negedge clk);
    op_s = op; a_s = a; b_s = b; imm_s = imm;
    #1;
    chk("R7 hold64", res64, prev64);
    chk("R7 hold32", {32'd0, res32}, {32'd0, prev32});
    @(posedge clk); #1;
    e64 = ref64(op, a, b, imm);
    e32 = ref32(op, a, b);
    chk(tag, res64, e64);
    chk("R6 wide flag", {63'd0, uns64}, 64'd0);
    chk("R6 narrow result", {32'd0, res32}, e32);
    chk("R6 narrow flag", {63'd0, uns32}, {63'd0, (op >= 3'd3)});
    prev64 = e64;
    prev32 = e32[31:0];
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : stim
    // R8: reset with live operands
    op_s = 3'd2; a_s = 64'hFFFF; b_s = 64'h77; imm_s = 6'd5;
    repeat (3) @(posedge clk);
    #1;
    chk("R8 res64", res64, 64'd0);
    chk("R8 flag64", {63'd0, uns64}, 64'd0);
    chk("R8 res32", {32'd0, res32}, 64'd0);
    chk("R8 flag32", {63'd0, uns32}, 64'd0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    prev64 = ref64(3'd2, 64'hFFFF, 64'h77, 6'd5);
    prev32 = ref32(3'd2, 64'hFFFF, 64'h77)+0;

    // corner grid over every operation: R1 R2 R3 R4 R5 R6
    for (int op = 0; op < 8; op++)
      for (int ia = 0; ia < 8; ia++)
        for (int ib = 0; ib < 8; ib++)
          run(3'(op), corner(ia), corner(ib), 6'(ia * 7 + ib), tag_of(3'(op)));

    // R4: full immediate sweep, base must not matter
    for (int s = 0; s < 64; s++) begin
      run(3'd7, 64'hDEAD_BEEF_8000_0001, 64'hFFFF_FFFF_FFFF_FFFF, 6'(s), "R4");
      chk("R4 imm", res64, ({32'd0, 32'h8000_0001} << s));
    end

    // R3: word add with zero base acts as a zero-extend
    run(3'd3, 64'hABCD_0000_F000_0001, 64'd0, 6'd0, "R3");
    chk("R3 zext", res64, 64'h0000_0000_F000_0001);

    // R5: wrap around the top
    run(3'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 6'd0, "R5");
    chk("R5 wrap", res64, 64'hFFFF_FFFF_FFFF_FFF7);
    run(3'd6, 64'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 6'd0, "R5");
    chk("R5 wrap word", res64, 64'h0000_0007_FFFF_FFF7);

    // R9: upper half of index must not change word results
    for (int op = 3; op < 8; op++) begin
      logic [63:0] r0;
      run(3'(op), 64'h0000_0000_1357_9BDF, 64'h1000, 6'd9, "R9");
      r0 = res64;
      run(3'(op), 64'hFFFF_FFFF_1357_9BDF, 64'h1000, 6'd9, "R9");
      chk("R9 upper ignored", res64, r0);
    end

    // random vectors
    for (int k = 0; k < 3000; k++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 7));
      run(op, {$urandom, $urandom}, {$urandom, $urandom}, 6'($urandom), tag_of(op));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule